// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor core that completes one instruction in every clock cycle. It supports six operations:

- register add and register subtract, both wrapping modulo 2^32;
- OR with a zero-extended 16-bit constant;
- word load and word store, each addressed by a base register plus a signed 16-bit offset;
- a conditional relative branch taken when two registers are equal.

All of the work happens in one cycle. The program counter selects a word from an external instruction memory. A combinational decoder then sets the control points: destination choice, ALU operand source, extension mode, ALU function, memory write, write-back source and next-PC choice. The operands come from a 32 x 32 register file, the ALU result or the loaded word goes back, and the PC, the register file and the data memory all update together on the rising clock edge.

Both memories sit outside the core and are read combinationally. The core presents one address and a write strobe to each memory, and the data memory is written on the same edge that retires the store.

Top module: `mcpu_core`

## Requirements
- R1: While `rst_n` is low at a rising edge, the PC becomes 0. While `rst_n` is low, `dmem_we` stays 0 and no register is written, even if the fetched word is a store.
- R2: A word with bits[31:26]=0x00, bits[10:6]=0 and bits[5:0]=0x21 writes R[b25:21]+R[b20:16] into R[b15:11]. The same layout with bits[5:0]=0x23 writes R[b25:21]−R[b20:16] into R[b15:11]. Both results wrap modulo 2^32.
- R3: Opcode 0x0D (bits[31:26]) writes R[b25:21] OR {16'h0000, b15:0} into R[b20:16].
- R4: Opcode 0x23 loads the data word at R[b25:21] + sign-extended b15:0 into R[b20:16]. Opcode 0x2B drives that same address, with R[b20:16] on `dmem_wdata` and `dmem_we`=1, and writes no register. No other instruction raises `dmem_we`.
- R5: Every instruction other than a taken branch sets the next PC to PC+4.
- R6: Opcode 0x04 compares R[b25:21] with R[b20:16] through the ALU zero flag. If they are equal, the next PC is PC+4+(sign-extended b15:0 × 4), and negative offsets branch backwards. If they differ, the next PC is PC+4.
- R7: Register 0 always reads as 0. A write that targets register 0 is discarded.
- R8: Any other opcode, an R-type word with a different function code, or an R-type word with nonzero bits[10:6] writes no register, does not write memory, and advances the PC by 4.
- R9: An instruction whose destination is also one of its sources reads the old value during its cycle. The newly written value is what the next instruction sees.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | 32 | Byte address of the instruction to fetch (the PC) |
| imem_rdata | input | 32 | Instruction word returned combinationally |
| dmem_addr | output | 32 | Byte address for a load or store (ALU result) |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Data-memory write strobe, taken on the rising edge |
| dmem_rdata | input | 32 | Load data returned combinationally |

## Verification
In a single cycle, the register file is both read and written at the same index when an instruction names its own destination as a source. The bench provokes this with a chain of self-doubling adds. It then stores the result and compares it with the value that old-operand semantics predict. A second overlap is a store fetched while reset is held low: the bench keeps a store at address 0 during reset and expects the memory strobe to stay low. The branch paths are judged from a per-cycle trace of expected fetch addresses that the scoreboard compares with `imem_addr`.

// File: rtl/mcpu_pkg.sv
// Package: shared encodings and control-point types for the single-cycle core.
// Assumes the fixed 32-bit instruction layout with a 6-bit opcode in bits 31:26.
package mcpu_pkg;

    localparam int unsigned OPW = 6;
    localparam int unsigned FNW = 6;
    localparam int unsigned SHW = 5;
    localparam int unsigned IMW = 16;

    localparam logic [OPW-1:0] OPC_RTYPE = 6'h00;
    localparam logic [OPW-1:0] OPC_ORI   = 6'h0D;
    localparam logic [OPW-1:0] OPC_LOAD  = 6'h23;
    localparam logic [OPW-1:0] OPC_STORE = 6'h2B;
    localparam logic [OPW-1:0] OPC_BREQ  = 6'h04;
    localparam logic [FNW-1:0] FN_ADDU   = 6'h21;
    localparam logic [FNW-1:0] FN_SUBU   = 6'h23;

    typedef enum logic [1:0] {ALU_ADD = 2'd0, ALU_SUB = 2'd1, ALU_OR = 2'd2} alu_op_e;
    typedef enum logic {DST_RT = 1'b0, DST_RD = 1'b1}        dst_sel_e;
    typedef enum logic {BSRC_REG = 1'b0, BSRC_IMM = 1'b1}    bsrc_e;
    typedef enum logic {EXT_ZERO = 1'b0, EXT_SIGN = 1'b1}    ext_e;
    typedef enum logic {WB_ALU = 1'b0, WB_MEM = 1'b1}        wb_e;
    typedef enum logic {NPC_SEQ = 1'b0, NPC_BREQ = 1'b1}     npc_e;

    typedef struct packed {
        logic     reg_we;
        dst_sel_e dst;
        bsrc_e    bsrc;
        ext_e     ext;
        alu_op_e  alu;
        logic     mem_we;
        wb_e      wb;
        npc_e     npc;
        logic     legal;
    } ctrl_t;

endpackage

// File: rtl/mcpu_decoder.sv
// Module: combinational main decoder. Maps opcode, function and shift fields
// onto the control points. Assumes unknown encodings must behave as no-ops.
module mcpu_decoder
    import mcpu_pkg::*;
(
    input  logic [OPW-1:0] op_i,
    input  logic [FNW-1:0] funct_i,
    input  logic [SHW-1:0] shamt_i,
    output ctrl_t          ctrl_o
);

    // Purpose: derive every control point from the instruction fields.
    always_comb begin
        ctrl_o.reg_we = 1'b0;
        ctrl_o.dst    = DST_RT;
        ctrl_o.bsrc   = BSRC_REG;
        ctrl_o.ext    = EXT_ZERO;
        ctrl_o.alu    = ALU_ADD;
        ctrl_o.mem_we = 1'b0;
        ctrl_o.wb     = WB_ALU;
        ctrl_o.npc    = NPC_SEQ;
        ctrl_o.legal  = 1'b0;
        unique case (op_i)
            OPC_RTYPE: begin
                if (shamt_i == '0 && (funct_i == FN_ADDU || funct_i == FN_SUBU)) begin
                    ctrl_o.reg_we = 1'b1;
                    ctrl_o.dst    = DST_RD;
                    ctrl_o.alu    = (funct_i == FN_SUBU) ? ALU_SUB : ALU_ADD;
                    ctrl_o.legal  = 1'b1;
                end
            end
            OPC_ORI: begin
                ctrl_o.reg_we = 1'b1;
                ctrl_o.bsrc   = BSRC_IMM;
                ctrl_o.alu    = ALU_OR;
                ctrl_o.legal  = 1'b1;
            end
            OPC_LOAD: begin
                ctrl_o.reg_we = 1'b1;
                ctrl_o.bsrc   = BSRC_IMM;
                ctrl_o.ext    = EXT_SIGN;
                ctrl_o.wb     = WB_MEM;
                ctrl_o.legal  = 1'b1;
            end
            OPC_STORE: begin
                ctrl_o.bsrc   = BSRC_IMM;
                ctrl_o.ext    = EXT_SIGN;
                ctrl_o.mem_we = 1'b1;
                ctrl_o.legal  = 1'b1;
            end
            OPC_BREQ: begin
                ctrl_o.ext    = EXT_SIGN;
                ctrl_o.alu    = ALU_SUB;
                ctrl_o.npc    = NPC_BREQ;
                ctrl_o.legal  = 1'b1;
            end
            default: ;
        endcase
    end

    // Purpose: an unrecognised word must leave registers, memory and PC flow alone.
    always_comb begin
        if (!ctrl_o.legal) begin
            assert_illegal_quiet_R8: assert (!ctrl_o.reg_we && !ctrl_o.mem_we && ctrl_o.npc == NPC_SEQ);
        end
    end

endmodule

// File: rtl/mcpu_alu.sv
// Module: ALU with add, subtract and OR, plus a zero flag on the result.
// Assumes the branch equality test is a subtract whose result is zero.
module mcpu_alu
    import mcpu_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  alu_op_e      op_i,
    output logic [W-1:0] y_o,
    output logic         zero_o
);

    // Purpose: select the arithmetic or logic result.
    always_comb begin
        unique case (op_i)
            ALU_SUB: y_o = a_i - b_i;
            ALU_OR:  y_o = a_i | b_i;
            default: y_o = a_i + b_i;
        endcase
    end

    // Purpose: flag an all-zero result for the branch comparison.
    assign zero_o = (y_o == '0);

    // Purpose: a subtract flags zero exactly when the operands match.
    always_comb begin
        if (op_i == ALU_SUB && !$isunknown({a_i, b_i})) begin
            assert_eq_flag_R6: assert (zero_o == (a_i == b_i));
        end
    end

endmodule

// File: rtl/mcpu_regfile.sv
// Module: register file with two combinational read ports and one write port
// taken on the rising edge. Entry 0 is hard-wired to zero. Assumes the
// contents are defined by software before first use, so they are not reset.
module mcpu_regfile #(
    parameter  int unsigned W  = 32,
    parameter  int unsigned N  = 32,
    localparam int unsigned AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [W-1:0]  wdata_i,
    input  logic [AW-1:0] raddr_a_i,
    output logic [W-1:0]  rdata_a_o,
    input  logic [AW-1:0] raddr_b_i,
    output logic [W-1:0]  rdata_b_o
);

    logic [W-1:0] regs [N];

    for (genvar g = 0; g < N; g++) begin : gen_reg
        if (g == 0) begin : gen_zero
            assign regs[g] = '0;
        end else begin : gen_store
            logic [W-1:0] q;
            // Purpose: capture write data when this entry is addressed.
            always_ff @(posedge clk) begin
                if (we_i && waddr_i == AW'(g)) begin
                    q <= wdata_i;
                end
            end
            assign regs[g] = q;

            assert_write_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (we_i && waddr_i == AW'(g)) |=> (q == $past(wdata_i)));
        end
    end

    // Purpose: combinational read of both source operands.
    assign rdata_a_o = regs[raddr_a_i];
    assign rdata_b_o = regs[raddr_b_i];

    // Purpose: entry 0 reads as zero on both ports.
    always_comb begin
        if (raddr_a_i == '0) begin
            assert_zero_reg_a_R7: assert (rdata_a_o == '0);
        end
        if (raddr_b_i == '0) begin
            assert_zero_reg_b_R7: assert (rdata_b_o == '0);
        end
    end

endmodule

// File: rtl/mcpu_core.sv
// Module: single-cycle core top. Holds the PC and connects the decoder,
// register file, extender, ALU and the write-back and next-PC multiplexers.
// Assumes both memories read combinationally and write on the rising edge.
module mcpu_core
    import mcpu_pkg::*;
#(
    parameter  int unsigned XLEN = 32,
    parameter  int unsigned NREG = 32,
    localparam int unsigned RAW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [XLEN-1:0] imem_addr,
    input  logic [XLEN-1:0] imem_rdata,
    output logic [XLEN-1:0] dmem_addr,
    output logic [XLEN-1:0] dmem_wdata,
    output logic            dmem_we,
    input  logic [XLEN-1:0] dmem_rdata
);

    localparam logic [XLEN-1:0] PC_STEP = XLEN'(4);

    logic [XLEN-1:0] pc_q, pc_next, pc_plus4, pc_branch;
    ctrl_t           ctrl;
    logic [RAW-1:0]  rs_f, rt_f, rd_f, waddr;
    logic [IMW-1:0]  imm_f;
    logic [XLEN-1:0] imm_ext, rs_val, rt_val, alu_b, alu_y, wb_data;
    logic            alu_zero, br_taken, rf_we;

    // Purpose: split the fetched word into its register and constant fields.
    assign rs_f  = imem_rdata[21 +: RAW];
    assign rt_f  = imem_rdata[16 +: RAW];
    assign rd_f  = imem_rdata[11 +: RAW];
    assign imm_f = imem_rdata[IMW-1:0];

    mcpu_decoder u_dec (
        .op_i    (imem_rdata[31:26]),
        .funct_i (imem_rdata[5:0]),
        .shamt_i (imem_rdata[10:6]),
        .ctrl_o  (ctrl)
    );

    // Purpose: gate architectural writes while reset is held.
    assign rf_we   = ctrl.reg_we & rst_n;
    assign dmem_we = ctrl.mem_we & rst_n;

    // Purpose: choose the destination register field.
    assign waddr = (ctrl.dst == DST_RD) ? rd_f : rt_f;

    mcpu_regfile #(.W(XLEN), .N(NREG)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (rf_we),
        .waddr_i   (waddr),
        .wdata_i   (wb_data),
        .raddr_a_i (rs_f),
        .rdata_a_o (rs_val),
        .raddr_b_i (rt_f),
        .rdata_b_o (rt_val)
    );

    // Purpose: widen the 16-bit constant by zero or sign fill.
    assign imm_ext = (ctrl.ext == EXT_SIGN) ? {{(XLEN-IMW){imm_f[IMW-1]}}, imm_f}
                                            : {{(XLEN-IMW){1'b0}}, imm_f};

    // Purpose: pick the ALU second operand.
    assign alu_b = (ctrl.bsrc == BSRC_IMM) ? imm_ext : rt_val;

    mcpu_alu #(.W(XLEN)) u_alu (
        .a_i    (rs_val),
        .b_i    (alu_b),
        .op_i   (ctrl.alu),
        .y_o    (alu_y),
        .zero_o (alu_zero)
    );

    // Purpose: choose the value written back into the register file.
    assign wb_data = (ctrl.wb == WB_MEM) ? dmem_rdata : alu_y;

    // Purpose: data-memory request from the ALU address and the rt operand.
    assign dmem_addr  = alu_y;
    assign dmem_wdata = rt_val;

    // Purpose: sequential and branch-target next-PC values.
    assign br_taken  = (ctrl.npc == NPC_BREQ) & alu_zero;
    assign pc_plus4  = pc_q + PC_STEP;
    assign pc_branch = pc_plus4 + (imm_ext << 2);
    assign pc_next   = br_taken ? pc_branch : pc_plus4;

    // Purpose: program counter register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_next;
        end
    end

    assign imem_addr = pc_q;

    // Purpose: no memory write escapes while reset is held.
    always_comb begin
        if (!rst_n) begin
            assert_mem_quiet_R1: assert (!dmem_we);
        end
    end

    // Purpose: a store never also writes the register file.
    always_comb begin
        if (dmem_we) begin
            assert_store_no_rf_R4: assert (!rf_we);
        end
    end

    assert_pc_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !br_taken |=> (pc_q == $past(pc_q) + PC_STEP));

    assert_branch_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |=> (pc_q == $past(pc_q) + PC_STEP + ($past(imm_ext) << 2)));

endmodule

// File: tb/mcpu_core_tb.sv
// Bench: a driver loads a program and queues the expected fetch addresses and
// stores; a monitor pops and compares them against the core's ports each cycle.
module mcpu_core_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;

    logic [31:0] imem [32];
    logic [31:0] dmem [64];

    int  n_chk = 0;
    int  n_err = 0;
    bit  run   = 1'b0;
    bit  done  = 1'b0;

    typedef struct { logic [31:0] addr; logic [31:0] data; string req; } store_t;
    typedef struct { logic [31:0] pc; string req; } fetch_t;
    store_t st_q[$];
    fetch_t pc_q[$];

    always #2 clk = ~clk;

    mcpu_core u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata)
    );

    assign imem_rdata = imem[imem_addr[6:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];

    always @(posedge clk) begin
        if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
    end

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic push_store(logic [31:0] a, logic [31:0] d, string req);
        store_t s;
        s.addr = a; s.data = d; s.req = req;
        st_q.push_back(s);
    endtask

    task automatic push_fetch(int idx, string req);
        fetch_t f;
        f.pc = 32'(idx * 4); f.req = req;
        pc_q.push_back(f);
    endtask

    // Monitor: compare fetch address and any store against the queues.
    always @(negedge clk) begin
        if (run) begin
            if (pc_q.size() != 0) begin
                fetch_t f;
                f = pc_q.pop_front();
                check(imem_addr == f.pc, f.req, imem_addr, f.pc);
            end
            if (dmem_we) begin
                if (st_q.size() == 0) begin
                    check(1'b0, "R8 unexpected store", dmem_addr, 32'h0);
                end else begin
                    store_t s;
                    s = st_q.pop_front();
                    check(dmem_addr == s.addr, s.req, dmem_addr, s.addr);
                    check(dmem_wdata == s.data, s.req, dmem_wdata, s.data);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #20000;
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    // Driver: program, expectations, reset and run.
    initial begin
        rst_n = 1'b0;
        for (int i = 0; i < 32; i++) imem[i] = 32'h0;
        for (int i = 0; i < 64; i++) dmem[i] = 32'h0;

        imem[0]  = enc_i(6'h2B, 0, 0, 16'h003C);          // store at reset vector
        imem[1]  = enc_i(6'h0D, 0, 1, 16'h0005);          // r1 = 5
        imem[2]  = enc_i(6'h0D, 0, 2, 16'hFFFF);          // r2 = 0000FFFF
        imem[3]  = enc_i(6'h2B, 0, 2, 16'h0000);          // R3 store
        imem[4]  = enc_r(1, 2, 3, 6'h21);                 // r3 = r1 + r2
        imem[5]  = enc_i(6'h2B, 0, 3, 16'h0004);
        imem[6]  = enc_r(1, 2, 4, 6'h23);                 // r4 = r1 - r2
        imem[7]  = enc_i(6'h2B, 0, 4, 16'h0008);
        imem[8]  = enc_i(6'h0D, 0, 5, 16'h0020);          // r5 = 32
        imem[9]  = enc_i(6'h2B, 5, 1, 16'hFFFC);          // mem[28] = r1
        imem[10] = enc_i(6'h23, 5, 6, 16'hFFFC);          // r6 = mem[28]
        imem[11] = enc_r(6, 6, 7, 6'h21);                 // r7 = r6 + r6
        imem[12] = enc_i(6'h2B, 0, 7, 16'h000C);
        imem[13] = enc_i(6'h0D, 0, 0, 16'h1234);          // write to r0 dropped
        imem[14] = enc_i(6'h2B, 0, 0, 16'h0010);
        imem[15] = enc_r(1, 1, 8, 6'h21);                 // r8 = 10
        imem[16] = enc_r(8, 8, 8, 6'h21);                 // r8 = r8 + r8
        imem[17] = enc_i(6'h2B, 0, 8, 16'h0014);
        imem[18] = enc_i(6'h04, 1, 6, 16'h0002);          // taken, to 21
        imem[19] = enc_i(6'h2B, 0, 1, 16'h0018);          // skipped
        imem[20] = enc_i(6'h2B, 0, 1, 16'h0018);          // skipped
        imem[21] = enc_i(6'h04, 1, 2, 16'h0005);          // not taken
        imem[22] = enc_i(6'h2B, 0, 2, 16'h0018);
        imem[23] = enc_i(6'h08, 1, 1, 16'h0007);          // unknown opcode
        imem[24] = enc_r(2, 2, 1, 6'h20);                 // unknown function
        imem[25] = enc_i(6'h2B, 0, 1, 16'h0020);
        imem[26] = enc_i(6'h04, 0, 0, 16'hFFFF);          // branch to self

        push_store(32'h00, 32'h0000FFFF, "R3 ori zero-extend");
        push_store(32'h04, 32'h00010004, "R2 add");
        push_store(32'h08, 32'hFFFF0006, "R2 sub wrap");
        push_store(32'h1C, 32'h00000005, "R4 store negative offset");
        push_store(32'h0C, 32'h0000000A, "R4 load data");
        push_store(32'h10, 32'h00000000, "R7 r0 stays zero");
        push_store(32'h14, 32'h00000014, "R9 same-cycle read/write");
        push_store(32'h18, 32'h0000FFFF, "R6 not-taken path");
        push_store(32'h20, 32'h00000005, "R8 unknown words inert");

        for (int i = 1; i <= 18; i++) push_fetch(i, "R5 sequential PC");
        push_fetch(21, "R6 taken branch target");
        push_fetch(22, "R6 not-taken branch");
        for (int i = 23; i <= 26; i++) push_fetch(i, "R5 sequential PC");
        for (int i = 0; i < 6; i++) push_fetch(26, "R6 backward branch");

        repeat (3) @(negedge clk);
        check(imem_addr == 32'h0, "R1 reset PC", imem_addr, 32'h0);
        check(dmem_we == 1'b0, "R1 store held off in reset", 32'(dmem_we), 32'h0);
        #1;
        rst_n = 1'b1;
        run   = 1'b1;

        while (pc_q.size() != 0) @(negedge clk);
        #1;
        run = 1'b0;
        check(st_q.size() == 0, "R4 all stores seen", 32'(st_q.size()), 32'h0);

        rst_n = 1'b0;
        @(negedge clk);
        check(imem_addr == 32'h0, "R1 mid-run reset PC", imem_addr, 32'h0);
        check(dmem_we == 1'b0, "R1 store held off in reset", 32'(dmem_we), 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule